// File: doc/BRIEF.md
# Endpoint Forced-Stall Controller

This block decides, token by token, whether a USB device function answers an endpoint with a STALL handshake or with its normal reply. Firmware asks for a stall by setting a per-endpoint request bit through a small register port. The block keeps a second bit per endpoint, a stall-status bit that firmware cannot write. The packet engine reports IN/OUT tokens as strobes carrying an endpoint number. The request parser reports a host Clear Feature (endpoint halt) as a strobe with an endpoint number in the same way.

When a token finds the request bit set, the status bit is latched. From then on the endpoint stalls until the host clears the status bit with Clear Feature. Clear Feature never touches the request bit. If firmware still holds the request high, the next token latches the stall again. With the global auto-clear enable on, hardware drops the request bit at the moment the status bit latches, so the host's Clear Feature on its own ends the stall. The enable only governs stalls that firmware requests while it is already on.

Top module: `ep_stall_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every request bit, every status bit and the auto-clear enable read 0, and no handshake is produced.
- R2: A token strobe in cycle n gives exactly one handshake strobe in cycle n+1. No handshake appears without a token.
- R3: A token to an endpoint whose request bit is 1 is answered with STALL (hs_stall=1) and sets that endpoint's status bit. Status bits change only on tokens, Clear Feature and reset.
- R4: While an endpoint's status bit is 1, every token to it is answered with STALL, even after its request bit has been written 0.
- R5: Clear Feature for an endpoint clears only that endpoint's status bit. All request bits are left unchanged.
- R6: Once the request bit has been cleared and Clear Feature received, later tokens to that endpoint get the normal handshake (hs_stall=0).
- R7: If Clear Feature arrives while the request bit is still 1, the next token to that endpoint is answered with STALL and sets the status bit again.
- R8: With auto-clear enabled before firmware sets a request bit, the token that latches the status bit also clears that request bit. A single Clear Feature then restores normal handshakes.
- R9: A request bit set while auto-clear is 0 is not auto-cleared, even if auto-clear is turned on before the stall latches.
- R10: A register write and a token or Clear Feature in the same cycle: the write takes effect first, and the event is judged on the written value.
- R11: Register map on reg_addr: 0 = request bits (read/write, bit i = endpoint i), 1 = auto-clear enable (bit 0, read/write), 2 = status bits (read-only; writes are ignored), 3 reads 0.
- R12: A token and Clear Feature to the same endpoint in the same cycle: the token is judged first, and the status bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | NUM_EP | Write data |
| reg_rdata | output | NUM_EP | Read data, combinational from reg_addr |
| tok_valid | input | 1 | IN/OUT token strobe |
| tok_ep | input | EPW | Endpoint of the token |
| clrf_valid | input | 1 | Clear Feature (endpoint halt) strobe |
| clrf_ep | input | EPW | Endpoint of the Clear Feature |
| hs_valid | output | 1 | Handshake decision strobe, one cycle after the token |
| hs_stall | output | 1 | 1 = STALL, 0 = normal handshake |

## Verification
The bench targets the re-latch after Clear Feature with the request still high. A design that let Clear Feature also clear the request, or that latched the status bit continuously, would disagree on the status readback or on the next handshake. It checks that the auto-clear enable is sampled when the request is written, so a design that reads the live enable would wrongly drop a request set earlier. It also drives the same-cycle collisions: write plus token, and token plus Clear Feature. A design with the wrong ordering returns a stale handshake or leaves a stuck status bit. A long pseudo-random sweep over all four endpoints compares every handshake and every register read against an arithmetic model.

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl #(
  parameter int NUM_EP = 4,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [NUM_EP-1:0] reg_wdata,
  output logic [NUM_EP-1:0] reg_rdata,
  input  logic              tok_valid,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              clrf_valid,
  input  logic [EPW-1:0]    clrf_ep,
  output logic              hs_valid,
  output logic              hs_stall
);

  localparam logic [1:0] A_REQ  = 2'd0;
  localparam logic [1:0] A_AUTO = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic [NUM_EP-1:0] req_q, stat_q, arm_q;
  logic              auto_q;

  logic [NUM_EP-1:0] tok_hit, clr_hit;
  logic [NUM_EP-1:0] req_w, arm_w, latch, req_d;
  logic              wr_req, wr_auto, stall_now;

  assign wr_req  = reg_we && (reg_addr == A_REQ);
  assign wr_auto = reg_we && (reg_addr == A_AUTO);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign tok_hit[i] = tok_valid  && (tok_ep  == EPW'(i));
    assign clr_hit[i] = clrf_valid && (clrf_ep == EPW'(i));
    assign req_w[i]   = wr_req ? reg_wdata[i] : req_q[i];
    assign arm_w[i]   = !wr_req      ? arm_q[i] :
                        !reg_wdata[i] ? 1'b0     :
                        req_q[i]      ? arm_q[i] : auto_q;
  end

  assign latch     = tok_hit & req_w & ~stat_q;
  assign stall_now = |(tok_hit & (stat_q | req_w));
  assign req_d     = req_w & ~(latch & arm_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      stat_q   <= '0;
      arm_q    <= '0;
      auto_q   <= 1'b0;
      hs_valid <= 1'b0;
      hs_stall <= 1'b0;
    end else begin
      req_q    <= req_d;
      arm_q    <= arm_w & req_d;
      stat_q   <= (stat_q | (tok_hit & req_w)) & ~clr_hit;
      if (wr_auto) auto_q <= reg_wdata[0];
      hs_valid <= tok_valid;
      hs_stall <= tok_valid && stall_now;
    end
  end

  always_comb begin
    case (reg_addr)
      A_REQ:   reg_rdata = req_q;
      A_AUTO:  reg_rdata = NUM_EP'(auto_q);
      A_STAT:  reg_rdata = stat_q;
      default: reg_rdata = '0;
    endcase
  end

  p_hs_follows_tok_r2: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> hs_valid);
  p_no_spurious_hs_r2: assert property (@(posedge clk) disable iff (rst)
    !tok_valid |=> !hs_valid);
  p_stat_forces_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && stat_q[tok_ep]) |=> (hs_valid && hs_stall));
  p_clear_drops_stat_r5: assert property (@(posedge clk) disable iff (rst)
    clrf_valid |=> !stat_q[$past(clrf_ep)]);
  p_clear_keeps_req_r5: assert property (@(posedge clk) disable iff (rst)
    (clrf_valid && !tok_valid && !reg_we) |=> (req_q == $past(req_q)));
  p_stat_rises_on_token_r3: assert property (@(posedge clk) disable iff (rst)
    (tok_valid == 1'b0) |=> ((stat_q & ~$past(stat_q)) == '0));
  p_req_set_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && req_w[tok_ep]) |=> hs_stall);
  p_unarmed_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && (req_q & ~arm_q) != '0) |=> ((req_q & ~$past(arm_q)) == ($past(req_q) & ~$past(arm_q))));

endmodule

// File: tb/ep_stall_ctrl_tb.sv
`timescale 1ns/1ps
module ep_stall_ctrl_tb;
  localparam int N = 4;
  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [N-1:0] reg_wdata = 0, reg_rdata;
  logic tok_valid = 0, clrf_valid = 0;
  logic [1:0] tok_ep = 0, clrf_ep = 0;
  logic hs_valid, hs_stall;

  int n_tests = 0, n_fail = 0;
  logic [N-1:0] m_req = 0, m_stat = 0, m_arm = 0;
  logic m_auto = 0;

  always #4 clk = ~clk;

  ep_stall_ctrl #(.NUM_EP(N)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .clrf_valid(clrf_valid), .clrf_ep(clrf_ep),
    .hs_valid(hs_valid), .hs_stall(hs_stall));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [1:0] a, input logic [N-1:0] d,
                      input logic tv, input logic [1:0] te, input logic cv, input logic [1:0] ce);
    logic [N-1:0] rw, aw, th, lt, rd;
    logic st;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    tok_valid = tv; tok_ep = te; clrf_valid = cv; clrf_ep = ce;
    @(posedge clk);
    rw = (we && a == 0) ? d : m_req;
    for (int i = 0; i < N; i++)
      aw[i] = !(we && a == 0) ? m_arm[i] : !d[i] ? 1'b0 : m_req[i] ? m_arm[i] : m_auto;
    th = tv ? (N'(1) << te) : '0;
    lt = th & rw & ~m_stat;
    st = |(th & (m_stat | rw));
    rd = rw & ~(lt & aw);
    m_arm = aw & rd;
    m_stat = (m_stat | (th & rw)) & ~(cv ? (N'(1) << ce) : '0);
    m_req = rd;
    if (we && a == 1) m_auto = d[0];
    #1;
    chk({tag, " R2 hs_valid"}, N'(hs_valid), N'(tv));
    if (tv) chk({tag, " hs_stall"}, N'(hs_stall), N'(st));
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a);
    logic [N-1:0] e;
    @(negedge clk);
    reg_we = 0; tok_valid = 0; clrf_valid = 0; reg_addr = a;
    #1;
    e = (a == 0) ? m_req : (a == 1) ? N'(m_auto) : (a == 2) ? m_stat : '0;
    chk({tag, " R11 read"}, reg_rdata, e);
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 4; a++) rd_chk(tag, 2'(a));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    rd_all("R1 reset");
    @(posedge clk); #1; chk("R1 no hs after reset", N'(hs_valid), '0);

    for (int e = 0; e < N; e++) begin
      logic [1:0] ep = 2'(e);
      logic [N-1:0] b = N'(1) << e;
      step("R3 set req", 1, 0, b, 0, 0, 0, 0);
      chk("R3 stat idle before token", m_stat, '0);
      rd_chk("R3", 2);
      step("R3 token stalls", 0, 0, 0, 1, ep, 0, 0);
      chk("R3 stall bit", m_stat, b); rd_chk("R3", 2);
      step("R4 drop req", 1, 0, '0, 0, 0, 0, 0);
      step("R4 stall persists", 0, 0, 0, 1, ep, 0, 0);
      step("R5 clear", 0, 0, 0, 0, 0, 1, ep);
      rd_all("R5");
      step("R6 normal", 0, 0, 0, 1, ep, 0, 0);
      chk("R6 normal hs", N'(hs_stall), '0);
      step("R7 set req", 1, 0, b, 0, 0, 0, 0);
      step("R7 latch", 0, 0, 0, 1, ep, 0, 0);
      step("R7 clear with req", 0, 0, 0, 0, 0, 1, ep);
      rd_all("R7 after clear");
      step("R7 relatch", 0, 0, 0, 1, ep, 0, 0);
      chk("R7 restall", N'(hs_stall), N'(1));
      rd_all("R7 relatched");
      step("R7 cleanup", 1, 0, '0, 0, 0, 1, ep);
      step("R8 auto on", 1, 1, N'(1), 0, 0, 0, 0);
      step("R8 set req", 1, 0, b, 0, 0, 0, 0);
      step("R8 token", 0, 0, 0, 1, ep, 0, 0);
      chk("R8 req autocleared", m_req, '0); rd_all("R8");
      step("R8 clear", 0, 0, 0, 0, 0, 1, ep);
      step("R8 normal", 0, 0, 0, 1, ep, 0, 0);
      chk("R8 normal hs", N'(hs_stall), '0);
      step("R9 auto off", 1, 1, '0, 0, 0, 0, 0);
      step("R9 set req", 1, 0, b, 0, 0, 0, 0);
      step("R9 auto on late", 1, 1, N'(1), 0, 0, 0, 0);
      step("R9 token", 0, 0, 0, 1, ep, 0, 0);
      chk("R9 req kept", m_req, b); rd_all("R9");
      step("R9 cleanup", 1, 0, '0, 0, 0, 1, ep);
      step("R10 write+token", 1, 0, b, 1, ep, 0, 0);
      chk("R10 stall on written value", N'(hs_stall), N'(1));
      step("R12 token+clear", 1, 0, '0, 1, ep, 1, ep);
      chk("R12 stall returned", N'(hs_stall), N'(1));
      rd_all("R12 stat cleared");
      step("R10 clear write+token", 1, 0, '0, 1, ep, 0, 0);
      chk("R10 normal on written value", N'(hs_stall), '0);
      step("R11 stat write ignored", 1, 2, '1, 0, 0, 0, 0);
      rd_all("R11");
      step("R1 auto off", 1, 1, '0, 0, 0, 0, 0);
    end

    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R3 R4 R7 R8 R10 sweep", lf[0] & lf[5], lf[2:1], lf[9:6], lf[3], lf[11:10],
           lf[4] & lf[12], lf[14:13]);
      if (k % 16 == 0) rd_all("sweep");
    end

    @(negedge clk); rst = 1; tok_valid = 0; reg_we = 0; clrf_valid = 0;
    @(posedge clk); @(negedge clk); rst = 0;
    m_req = 0; m_stat = 0; m_arm = 0; m_auto = 0;
    rd_all("R1 second reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule